// File: doc/BRIEF.md
# Vector special-function operation sequencer

This block carries out one complex-vector micro-op over a run of 16-bit elements held in a local single-port memory. A caller presents a function code, source and destination addresses, an element count, three flag bits and the current running maximum, then pulses `start`. The sequencer walks the source buffer one element at a time in ascending address order. For each element it reads the value, optionally subtracts the maximum, computes the result and writes it to the matching destination word. The destination word can either be overwritten or have the result added to it.

Transcendental functions (exp, sqrt, GELU, sin, cos, reciprocal) are not computed here. Each element goes to an external function unit over a request/acknowledge handshake, with at most one request outstanding. Reduce-sum and scaling are computed inside the block. The caller loads and inspects the memory through a host port while the block is idle.

The controller is one state machine:
- S_IDLE accepts `start`. It then goes to S_DONE (reserved code, or zero length for any function except reduce-sum), to S_WR or S_DRD (reduce-sum of length zero), to S_SRD (scale) or to S_RD (all other functions).
- S_SRD goes to S_SLAT, which latches the scale factor and goes to S_RD.
- S_RD goes to S_LAT, where the element read is ready.
- From S_LAT the controller goes to S_FU for a function-unit code. For reduce-sum it goes back to S_RD, or, after the last element, to S_DRD or S_WR. For scale it goes to S_DRD or S_WR.
- S_FU waits for `fu_ack`, then goes to S_DRD or S_WR.
- S_DRD goes to S_DLAT, which adds the old destination word and goes to S_WR.
- S_WR writes one word. It goes to S_RD if more elements remain, otherwise to S_DONE.
- S_DONE goes to S_IDLE.

Top module: `vsf_seq`

## Requirements
- R1: `busy` is high in every cycle after an accepted `start` until the operation ends. `done` is then high for exactly one cycle, during which `busy` is low. `err` is valid while `done` is high and holds until the next `start`. `start` is accepted only when both `busy` and `done` are low.
- R2: Function codes are 0 exp, 1 sqrt, 2 GELU, 3 sin, 4 cos, 5 reduce-sum, 6 scale and 7 reciprocal. For codes 0 to 4 and 7, each element i is sent to the function unit, and the returned value is written to word dst+i.
- R3: `fu_req` stays high with `fu_arg` and `fu_func` (the full 4-bit code) unchanged until `fu_ack` is seen high at a clock edge. The cycle after an acknowledge has `fu_req` low. Requests are issued one at a time, for elements src+0, src+1, … in ascending order.
- R4: Reduce-sum adds all prepared elements into a 32-bit wrapping accumulator. It then makes a single write of the low 16 bits to word dst+0.
- R5: Scale reads the factor once from word src+0 and multiplies each prepared element by it, keeping the low 16 bits. With `op_flags[1]` set it divides instead (unsigned, rounded down), and a factor of zero gives 16'hFFFF.
- R6: With `op_flags[2]` set, the `emax_in` value latched at `start` is subtracted, modulo 2^16, from every element before the operation. Later changes on `emax_in` have no effect.
- R7: With `op_flags[0]` set, each result is added, modulo 2^16, to the existing destination word instead of replacing it. For reduce-sum this applies to the single result word.
- R8: Codes 8 to 15 raise `done` with `err` high in the cycle after `start` and write no memory.
- R9: A zero length with any code other than reduce-sum raises `done` in the cycle after `start` with no write. A reduce-sum of length zero writes 0 (plus the old word when accumulating) to dst+0.
- R10: Counted in clock edges from the accepting edge to the one that raises `done`, with a = 2 when accumulating and 0 otherwise: a function-unit op with an acknowledge after one cycle takes 1+N(4+a), scale takes 3+N(3+a), and reduce-sum takes 2+2N+a.
- R11: While idle, `hst_we` writes `hst_wdata` to word `hst_addr` (modulo the memory depth). `hst_rdata` shows the word at `hst_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the operation described by the op_* inputs |
| op_func | input | 4 | Function code |
| op_src | input | 17 | Source buffer address |
| op_dst | input | 17 | Destination buffer address |
| op_len | input | 16 | Element count |
| op_flags | input | 3 | [2] subtract maximum, [1] divide when scaling, [0] accumulate |
| emax_in | input | 16 | Running maximum, latched at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved code seen |
| fu_req | output | 1 | Function-unit request |
| fu_func | output | 4 | Function code for the request |
| fu_arg | output | 16 | Prepared element for the request |
| fu_ack | input | 1 | Function-unit acknowledge, result valid |
| fu_res | input | 16 | Function-unit result |
| hst_we | input | 1 | Host write enable (idle only) |
| hst_addr | input | 17 | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Memory read data, one cycle after address |

## Verification
The bench counts clock edges from the edge that accepts `start` to the one that raises `done`, and compares the count with the R10 formula for each vector. This also places the one-cycle completion of reserved codes and zero lengths, and the `done` pulse is checked to drop one edge later. Results are not checked cycle by cycle. After each `done`, the bench reads the whole memory back through the host port, one edge per word, and compares it with an image computed from the requirements. The function-unit model acknowledges at the falling edge after it sees a request and logs each argument, so the order and count of requests can be compared with the expected sequence of prepared elements.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 17;
    localparam int LEN_W  = 16;
    localparam int ACC_W  = 32;
    localparam int FUNC_W = 4;

    // op_flags bit positions
    localparam int FLG_SUB = 2;
    localparam int FLG_DIV = 1;
    localparam int FLG_ACC = 0;

    localparam logic [FUNC_W-1:0] FN_RSUM  = 4'd5;
    localparam logic [FUNC_W-1:0] FN_SCALE = 4'd6;
    localparam logic [FUNC_W-1:0] FN_RECIP = 4'd7;

    typedef enum logic [3:0] {
        S_IDLE, S_SRD, S_SLAT, S_RD, S_LAT, S_FU, S_DRD, S_DLAT, S_WR, S_DONE
    } seq_state_t;

    function automatic logic is_fu_op(input logic [FUNC_W-1:0] f);
        return (f <= 4'd4) || (f == FN_RECIP);
    endfunction

    function automatic logic is_rsv(input logic [FUNC_W-1:0] f);
        return f[FUNC_W-1];
    endfunction
endpackage

// File: rtl/vsf_spram.sv
module vsf_spram #(
    parameter int DW    = 16,
    parameter int AW    = 17,
    parameter int DEPTH = 256,
    localparam int MAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0]  mem [DEPTH];
    logic [MAW-1:0] widx;

    assign widx = MAW'(addr % AW'(DEPTH));

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        rdata <= mem[widx];
    end
endmodule

// File: rtl/vsf_alu.sv
module vsf_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] emax,
    input  logic          sub_en,
    input  logic [DW-1:0] factor,
    input  logic          div_en,
    output logic [DW-1:0] prep,
    output logic [DW-1:0] scaled
);
    logic [DW-1:0] prod;
    logic [DW-1:0] quot;

    always_comb begin
        prep = sub_en ? (x - emax) : x;
        prod = prep * factor;
        quot = (factor == '0) ? '1 : (prep / factor);
        scaled = div_en ? quot : prod;
    end
endmodule

// File: rtl/vsf_seq.sv
module vsf_seq
    import vsf_pkg::*;
#(
    parameter int DW        = vsf_pkg::DATA_W,
    parameter int AW        = vsf_pkg::ADDR_W,
    parameter int LW        = vsf_pkg::LEN_W,
    parameter int AccW      = vsf_pkg::ACC_W,
    parameter int MEM_DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op_func,
    input  logic [AW-1:0] op_src,
    input  logic [AW-1:0] op_dst,
    input  logic [LW-1:0] op_len,
    input  logic [2:0]    op_flags,
    input  logic [DW-1:0] emax_in,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          fu_req,
    output logic [3:0]    fu_func,
    output logic [DW-1:0] fu_arg,
    input  logic          fu_ack,
    input  logic [DW-1:0] fu_res,
    input  logic          hst_we,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata
);
    seq_state_t    st, st_nx;

    logic [3:0]    func_q;
    logic [AW-1:0] src_q, dst_q;
    logic [LW-1:0] len_q, idx;
    logic          sub_q, div_q, accm_q;
    logic [DW-1:0] emax_q, factor_q, res_q;
    logic [AccW-1:0] acc_q, acc_sum;

    logic          seq_we;
    logic [AW-1:0] seq_addr, waddr;
    logic          port_we;
    logic [AW-1:0] port_addr;
    logic [DW-1:0] port_wdata, mem_rdata;
    logic [DW-1:0] alu_prep, alu_scaled;
    logic          last, rsum_q, start_ok;

    assign start_ok = start && (st == S_IDLE);
    assign last     = (({1'b0, idx} + 1'b1) == {1'b0, len_q});
    assign rsum_q   = (func_q == FN_RSUM);
    assign waddr    = dst_q + (rsum_q ? '0 : AW'(idx));
    assign acc_sum  = acc_q + AccW'(alu_prep);

    vsf_spram #(.DW(DW), .AW(AW), .DEPTH(MEM_DEPTH)) u_mem (
        .clk   (clk),
        .we    (port_we),
        .addr  (port_addr),
        .wdata (port_wdata),
        .rdata (mem_rdata)
    );

    vsf_alu #(.DW(DW)) u_alu (
        .x      (mem_rdata),
        .emax   (emax_q),
        .sub_en (sub_q),
        .factor (factor_q),
        .div_en (div_q),
        .prep   (alu_prep),
        .scaled (alu_scaled)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (start_ok) begin
                    if (is_rsv(op_func)) begin
                        st_nx = S_DONE;
                    end else if (op_len == '0) begin
                        if (op_func == FN_RSUM) begin
                            st_nx = op_flags[FLG_ACC] ? S_DRD : S_WR;
                        end else begin
                            st_nx = S_DONE;
                        end
                    end else if (op_func == FN_SCALE) begin
                        st_nx = S_SRD;
                    end else begin
                        st_nx = S_RD;
                    end
                end
            end
            S_SRD:  st_nx = S_SLAT;
            S_SLAT: st_nx = S_RD;
            S_RD:   st_nx = S_LAT;
            S_LAT: begin
                if (is_fu_op(func_q)) begin
                    st_nx = S_FU;
                end else if (rsum_q && !last) begin
                    st_nx = S_RD;
                end else begin
                    st_nx = accm_q ? S_DRD : S_WR;
                end
            end
            S_FU: begin
                if (fu_ack) begin
                    st_nx = accm_q ? S_DRD : S_WR;
                end
            end
            S_DRD:  st_nx = S_DLAT;
            S_DLAT: st_nx = S_WR;
            S_WR:   st_nx = (rsum_q || last) ? S_DONE : S_RD;
            S_DONE: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            len_q    <= '0;
            idx      <= '0;
            sub_q    <= 1'b0;
            div_q    <= 1'b0;
            accm_q   <= 1'b0;
            emax_q   <= '0;
            factor_q <= '0;
            res_q    <= '0;
            acc_q    <= '0;
            err      <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start_ok) begin
                        func_q <= op_func;
                        src_q  <= op_src;
                        dst_q  <= op_dst;
                        len_q  <= op_len;
                        sub_q  <= op_flags[FLG_SUB];
                        div_q  <= op_flags[FLG_DIV];
                        accm_q <= op_flags[FLG_ACC];
                        emax_q <= emax_in;
                        idx    <= '0;
                        acc_q  <= '0;
                        res_q  <= '0;
                        err    <= is_rsv(op_func);
                    end
                end
                S_SLAT: factor_q <= mem_rdata;
                S_LAT: begin
                    if (is_fu_op(func_q)) begin
                        res_q <= alu_prep;
                    end else if (rsum_q) begin
                        acc_q <= acc_sum;
                        idx   <= idx + 1'b1;
                        res_q <= acc_sum[DW-1:0];
                    end else begin
                        res_q <= alu_scaled;
                    end
                end
                S_FU: begin
                    if (fu_ack) begin
                        res_q <= fu_res;
                    end
                end
                S_DLAT: res_q <= res_q + mem_rdata;
                S_WR: begin
                    if (!rsum_q) begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and memory port
    always_comb begin
        busy     = (st != S_IDLE) && (st != S_DONE);
        done     = (st == S_DONE);
        fu_req   = (st == S_FU);
        fu_func  = func_q;
        fu_arg   = res_q;
        seq_we   = (st == S_WR);
        seq_addr = waddr;
        unique case (st)
            S_SRD:   seq_addr = src_q;
            S_RD:    seq_addr = src_q + AW'(idx);
            default: seq_addr = waddr;
        endcase
        if (st == S_IDLE) begin
            port_we    = hst_we;
            port_addr  = hst_addr;
            port_wdata = hst_wdata;
        end else begin
            port_we    = seq_we;
            port_addr  = seq_addr;
            port_wdata = res_q;
        end
        hst_rdata = mem_rdata;
    end
endmodule

// File: rtl/vsf_seq_chk.sv
module vsf_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  op_func,
    input logic [15:0] op_len,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        fu_req,
    input logic        fu_ack,
    input logic [3:0]  fu_func,
    input logic [15:0] fu_arg,
    input logic        seq_we
);
    logic idle_start;
    assign idle_start = start && !busy && !done;

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && op_func < 4'd8 && op_len > 16'd0) |=> busy);

    p_fu_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_req && !fu_ack) |=> (fu_req && $stable(fu_arg) && $stable(fu_func)));

    p_fu_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_req && fu_ack) |=> !fu_req);

    p_rsv_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && op_func >= 4'd8) |=> (done && err && !seq_we));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_start && op_len == 16'd0 && op_func < 4'd8 && op_func != 4'd5)
        |=> (done && !seq_we));
endmodule

bind vsf_seq vsf_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_func (op_func),
    .op_len  (op_len),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .fu_req  (fu_req),
    .fu_ack  (fu_ack),
    .fu_func (fu_func),
    .fu_arg  (fu_arg),
    .seq_we  (seq_we)
);

// File: tb/sim_vsf_seq.sv
module sim_vsf_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int NVEC = 11;

    typedef struct packed {
        logic [3:0]  func;
        logic [7:0]  src;
        logic [7:0]  dst;
        logic [15:0] len;
        logic [2:0]  flags;   // [2] sub, [1] div, [0] accm
        logic [15:0] emax;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 8'd0,  8'd128, 16'd4, 3'b000, 16'd0,   16'd17},
        '{4'd1, 8'd10, 8'd140, 16'd3, 3'b100, 16'd100, 16'd13},
        '{4'd2, 8'd20, 8'd150, 16'd2, 3'b001, 16'd0,   16'd13},
        '{4'd3, 8'd30, 8'd160, 16'd1, 3'b101, 16'd7,   16'd7},
        '{4'd4, 8'd0,  8'd170, 16'd5, 3'b000, 16'd0,   16'd21},
        '{4'd7, 8'd40, 8'd180, 16'd3, 3'b000, 16'd0,   16'd13},
        '{4'd5, 8'd0,  8'd200, 16'd8, 3'b000, 16'd0,   16'd18},
        '{4'd5, 8'd50, 8'd201, 16'd4, 3'b101, 16'd3,   16'd12},
        '{4'd6, 8'd60, 8'd210, 16'd4, 3'b000, 16'd0,   16'd15},
        '{4'd6, 8'd60, 8'd215, 16'd4, 3'b010, 16'd0,   16'd15},
        '{4'd6, 8'd64, 8'd225, 16'd2, 3'b001, 16'd0,   16'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_func = '0;
    logic [16:0] op_src = '0, op_dst = '0;
    logic [15:0] op_len = '0;
    logic [2:0]  op_flags = '0;
    logic [15:0] emax_in = '0;
    logic        busy, done, err, fu_req;
    logic [3:0]  fu_func;
    logic [15:0] fu_arg, fu_res;
    logic        fu_ack = 1'b0;
    logic        hst_we = 1'b0;
    logic [16:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0, hst_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] sh [DEPTH];
    logic [15:0] exp_log [64];
    logic [15:0] got_log [64];
    int nexp = 0;
    int ngot = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsf_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_func(op_func),
        .op_src(op_src), .op_dst(op_dst), .op_len(op_len), .op_flags(op_flags),
        .emax_in(emax_in), .busy(busy), .done(done), .err(err),
        .fu_req(fu_req), .fu_func(fu_func), .fu_arg(fu_arg),
        .fu_ack(fu_ack), .fu_res(fu_res),
        .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata)
    );

    // function-unit model: acknowledge one cycle after a request, log arguments
    assign fu_res = fu_arg * 16'd3 + {12'd0, fu_func};
    initial begin
        forever begin
            @(negedge clk);
            if (fu_req && !fu_ack) begin
                fu_ack = 1'b1;
                if (ngot < 64) got_log[ngot] = fu_arg;
                ngot++;
            end else begin
                fu_ack = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    task automatic host_write(input int a, input logic [15:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = 17'(a); hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
        sh[a % DEPTH] = d;
    endtask

    task automatic host_read(input int a, output logic [15:0] d);
        hst_addr = 17'(a);
        @(negedge clk);
        d = hst_rdata;
    endtask

    task automatic compare_image(input string req);
        logic [15:0] d;
        int bad = 0;
        int bad_a = 0;
        logic [15:0] bad_d = '0;
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a, d);
            if (d !== sh[a] && bad == 0) begin
                bad_a = a; bad_d = d;
            end
            if (d !== sh[a]) bad++;
        end
        check(bad == 0, req, $sformatf("memory word %0d", bad_a),
              int'(bad_d), int'(sh[bad_a]));
    endtask

    // reference model from the requirements
    task automatic model(input logic [3:0] f, input int src, input int dst,
                         input int len, input logic [2:0] fl, input logic [15:0] em);
        logic [15:0] x, v, r, s;
        logic [31:0] acc;
        acc = '0;
        nexp = 0;
        s = sh[src % DEPTH];
        if (f < 4'd8) begin
            for (int i = 0; i < len; i++) begin
                x = sh[(src + i) % DEPTH];
                v = fl[2] ? (x - em) : x;
                if (f == 4'd5) begin
                    acc = acc + {16'd0, v};
                end else begin
                    if (f == 4'd6) begin
                        r = fl[1] ? ((s == 16'd0) ? 16'hFFFF : v / s) : v * s;
                    end else begin
                        r = v * 16'd3 + {12'd0, f};
                        exp_log[nexp] = v;
                        nexp++;
                    end
                    if (fl[0]) r = r + sh[(dst + i) % DEPTH];
                    sh[(dst + i) % DEPTH] = r;
                end
            end
            if (f == 4'd5) begin
                r = acc[15:0];
                if (fl[0]) r = r + sh[dst % DEPTH];
                sh[dst % DEPTH] = r;
            end
        end
    endtask

    task automatic run(input logic [3:0] f, input int src, input int dst,
                       input int len, input logic [2:0] fl, input logic [15:0] em,
                       input int exp_cyc, input bit exp_err, input string req);
        int cyc;
        bit first_busy;
        @(negedge clk);
        op_func = f; op_src = 17'(src); op_dst = 17'(dst);
        op_len = 16'(len); op_flags = fl; emax_in = em;
        start = 1'b1;
        ngot = 0;
        @(negedge clk);
        start = 1'b0;
        emax_in = ~em;          // R6: later changes must not matter
        first_busy = busy;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == exp_cyc, "R10", "cycles to done", cyc, exp_cyc);
        if (exp_cyc > 1)
            check(first_busy == 1'b1, "R1", "busy after start", int'(first_busy), 1);
        check(err == exp_err, exp_err ? "R8" : "R1", "err with done", int'(err), int'(exp_err));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1", "done pulse ends",
              int'(done), 0);
        model(f, src, dst, len, fl, em);
        compare_image(req);
        if (nexp > 0) begin
            bit same;
            same = (ngot == nexp);
            for (int i = 0; i < nexp && i < 64; i++)
                if (got_log[i] !== exp_log[i]) same = 0;
            check(same, "R3", "request order/count", ngot, nexp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.flags[2]) return "R6";
        if (v.flags[0]) return "R7";
        if (v.func == 4'd5) return "R4";
        if (v.func == 4'd6) return "R5";
        return "R2";
    endfunction

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // reset state (R1)
        check(busy == 0 && done == 0 && err == 0 && fu_req == 0, "R1",
              "reset outputs", int'({busy, done, err, fu_req}), 0);
        rst_n = 1'b1;

        // preload memory (R11)
        for (int a = 0; a < DEPTH; a++)
            host_write(a, 16'((a * 1237 + 5) & 16'hFFFF));
        host_write(DEPTH + 3, 16'h5A5A);   // wraps to word 3
        host_read(3, d);
        check(d == 16'h5A5A, "R11", "host write/read wrap", int'(d), 16'h5A5A);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            run(VEC[k].func, int'(VEC[k].src), int'(VEC[k].dst), int'(VEC[k].len),
                VEC[k].flags, VEC[k].emax, int'(VEC[k].cyc), 1'b0, tag_of(VEC[k]));
        end

        // R8: reserved code, no writes
        run(4'd9, 0, 240, 3, 3'b000, 16'd0, 1, 1'b1, "R8");
        run(4'd15, 0, 241, 0, 3'b001, 16'd0, 1, 1'b1, "R8");
        // R9: zero length, non-reduce
        run(4'd0, 0, 242, 0, 3'b000, 16'd0, 1, 1'b0, "R9");
        // R9: zero-length reduce writes 0
        run(4'd5, 0, 243, 0, 3'b000, 16'd0, 2, 1'b0, "R9");
        // R5: divide by zero factor
        host_write(90, 16'd0);
        run(4'd6, 90, 230, 3, 3'b010, 16'd0, 12, 1'b0, "R5");
        // R6 + R5: subtract with divide
        run(4'd6, 70, 233, 3, 3'b110, 16'd9, 12, 1'b0, "R6");

        summary();
    end
endmodule